// File: doc/BRIEF.md
# Floating-Point Status Flag Accumulator

This block sits beside a floating-point datapath and collects the fine-grained status that each completed operation reports. When a status strobe arrives and the exception-enable input is high, the detailed cause bits are folded into eight sticky flags of a control/status register. Thirteen cause bits are reduced to those eight flags. The flags only accumulate. Hardware never clears them, and software clears or rewrites them through a plain write port.

After each accepted strobe, the block looks at the updated flag set. If any flag is set, it sends a one-cycle exception request to the exception controller, together with the program counter of the instruction that produced the status. The flags, the request and the captured PC are all registered, so they appear on the outputs on the clock edge that follows the strobe.

Top module: `fpu_flag_acc`

## Requirements
- R1: A status strobe (`st_valid`) taken while `exc_en` is low changes no flag and raises no request.
- R2: With `exc_en` high, any of the nine invalid-operation causes sets flag bit 0 (invalid). The cause bits are: 0 signalling NaN, 1 quiet NaN, 2 inf-minus-inf, 3 inf-div-inf, 4 zero-div-zero, 5 inf-times-zero, 6 conversion invalid, 7 compare invalid, 8 sqrt invalid.
- R3: Cause bit 0 also sets flag bit 1 (signalling NaN), and cause bit 1 also sets flag bit 2 (quiet NaN).
- R4: Cause bits 9 (overflow), 10 (underflow), 11 (divide-by-zero) and 12 (inexact) set only their own flags. These are flag bits 3, 4, 6 and 7 respectively.
- R5: Flag bit 5 (infinity) is set by cause bit 2 or cause bit 3 and by no other cause.
- R6: After a strobe accepted with `exc_en` high, `exc_req` is high in the next cycle exactly when the updated flags are non-zero. In that same cycle `exc_pc` holds the `prev_pc` value sampled with the strobe.
- R7: Hardware never clears a flag. A set flag stays set until a software write changes it.
- R8: A software write (`sw_wr_en`) without an accepted strobe replaces all eight flags with `sw_wr_data` on the next cycle and raises no request.
- R9: When a software write and an accepted strobe fall in the same cycle, the new flags are `sw_wr_data` OR the bits set by that strobe.
- R10: `exc_req` is a single-cycle pulse for each accepted strobe. It is low in any cycle that does not follow an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Status strobe from the floating-point unit |
| st_cause | input | 13 | Detailed cause bits, encoded as listed in R2 and R4 |
| prev_pc | input | PC_W | PC of the instruction reporting status |
| exc_en | input | 1 | Floating-point exception enable |
| sw_wr_en | input | 1 | Software write strobe for the flag field |
| sw_wr_data | input | 8 | Software write value |
| flags | output | 8 | Sticky flag field, encoded as listed in R2 to R5 |
| exc_req | output | 1 | Exception request pulse |
| exc_pc | output | PC_W | PC handed over with the request |

## Verification
The two functions that can land in the same cycle are the software write and the hardware flag update from an accepted strobe. The bench drives both in one cycle, first with a write that sets a flag the strobe does not touch, then with a write of zero that clears an older flag while a signalling-NaN cause arrives. It judges the outcome by checking the flags and the request in the following cycle against the OR rule. It also checks that a strobe taken with the enable low has no effect on either output.

// File: rtl/fpu_flag_pkg.sv
package fpu_flag_pkg;

    localparam int unsigned NUM_CAUSE = 13;
    localparam int unsigned NUM_FLAG  = 8;

    // cause bit positions
    localparam int unsigned C_SNAN = 0;
    localparam int unsigned C_QNAN = 1;
    localparam int unsigned C_ISI  = 2;
    localparam int unsigned C_IDI  = 3;
    localparam int unsigned C_ZDZ  = 4;
    localparam int unsigned C_IMZ  = 5;
    localparam int unsigned C_CVI  = 6;
    localparam int unsigned C_CMP  = 7;
    localparam int unsigned C_SQRT = 8;
    localparam int unsigned C_OVF  = 9;
    localparam int unsigned C_UNF  = 10;
    localparam int unsigned C_DZ   = 11;
    localparam int unsigned C_IX   = 12;
    localparam int unsigned NUM_INVALID = 9;

    // flag bit positions
    localparam int unsigned F_INV  = 0;
    localparam int unsigned F_SNAN = 1;
    localparam int unsigned F_QNAN = 2;
    localparam int unsigned F_OVF  = 3;
    localparam int unsigned F_UNF  = 4;
    localparam int unsigned F_INF  = 5;
    localparam int unsigned F_DZ   = 6;
    localparam int unsigned F_IX   = 7;

    typedef logic [NUM_CAUSE-1:0] cause_t;
    typedef logic [NUM_FLAG-1:0]  flag_t;

endpackage

// File: rtl/fpu_cause_map.sv
module fpu_cause_map
    import fpu_flag_pkg::*;
(
    input  cause_t cause_i,
    output flag_t  set_o
);
    logic invalid_any;

    // invalid causes occupy the low contiguous positions
    always_comb begin
        invalid_any = 1'b0;
        for (int k = 0; k < int'(NUM_INVALID); k++) begin
            invalid_any = invalid_any | cause_i[k];
        end
    end

    always_comb begin
        set_o         = '0;
        set_o[F_INV]  = invalid_any;
        set_o[F_SNAN] = cause_i[C_SNAN];
        set_o[F_QNAN] = cause_i[C_QNAN];
        set_o[F_INF]  = cause_i[C_ISI] | cause_i[C_IDI];
        set_o[F_OVF]  = cause_i[C_OVF];
        set_o[F_UNF]  = cause_i[C_UNF];
        set_o[F_DZ]   = cause_i[C_DZ];
        set_o[F_IX]   = cause_i[C_IX];
    end
endmodule

// File: rtl/fpu_flag_merge.sv
module fpu_flag_merge
    import fpu_flag_pkg::*;
(
    input  flag_t cur_i,
    input  logic  wr_en_i,
    input  flag_t wr_data_i,
    input  logic  hw_en_i,
    input  flag_t hw_set_i,
    output flag_t next_o
);
    flag_t base;

    always_comb begin
        base   = wr_en_i ? wr_data_i : cur_i;
        next_o = base | (hw_en_i ? hw_set_i : '0);
    end
endmodule

// File: rtl/fpu_flag_acc.sv
module fpu_flag_acc
    import fpu_flag_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [NUM_CAUSE-1:0] st_cause,
    input  logic [PC_W-1:0]      prev_pc,
    input  logic                 exc_en,
    input  logic                 sw_wr_en,
    input  logic [NUM_FLAG-1:0]  sw_wr_data,
    output logic [NUM_FLAG-1:0]  flags,
    output logic                 exc_req,
    output logic [PC_W-1:0]      exc_pc
);
    typedef struct packed {
        flag_t           flags;
        logic            req;
        logic [PC_W-1:0] pc;
    } state_t;

    state_t state_d, state_q;
    flag_t  hw_set;
    flag_t  merged;
    logic   accept;

    fpu_cause_map u_map (
        .cause_i (st_cause),
        .set_o   (hw_set)
    );

    fpu_flag_merge u_merge (
        .cur_i     (state_q.flags),
        .wr_en_i   (sw_wr_en),
        .wr_data_i (sw_wr_data),
        .hw_en_i   (accept),
        .hw_set_i  (hw_set),
        .next_o    (merged)
    );

    always_comb begin
        accept        = st_valid & exc_en;
        state_d       = state_q;
        state_d.flags = merged;
        state_d.req   = accept & (|merged);
        if (accept) begin
            state_d.pc = prev_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags   = state_q.flags;
    assign exc_req = state_q.req;
    assign exc_pc  = state_q.pc;

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !exc_en && !sw_wr_en) |=> ($stable(flags) && !exc_req));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    req_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (flags != '0));

    // R10
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && exc_en) |=> !exc_req);

    // R6
    pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && exc_en) |=> (exc_pc == $past(prev_pc)));

    // R5
    inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[F_INF] |-> hw_set[F_INV]);
endmodule

// File: tb/fpu_flag_acc_tb.sv
module fpu_flag_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic [12:0] st_cause;
    logic [31:0] prev_pc;
    logic        exc_en;
    logic        sw_wr_en;
    logic [7:0]  sw_wr_data;
    logic [7:0]  flags;
    logic        exc_req;
    logic [31:0] exc_pc;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fpu_flag_acc u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_cause(st_cause),
        .prev_pc(prev_pc), .exc_en(exc_en), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .flags(flags), .exc_req(exc_req), .exc_pc(exc_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, outputs sampled after the edge
    task automatic step(input logic v, input logic [12:0] c, input logic en,
                        input logic wr, input logic [7:0] wd, input logic [31:0] pc);
        st_valid = v; st_cause = c; exc_en = en; sw_wr_en = wr; sw_wr_data = wd; prev_pc = pc;
        @(posedge clk); #1;
        st_valid = 1'b0; st_cause = '0; sw_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 reset flags", {24'b0, flags}, 32'h0);
        chk("R10 reset req", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_gate_off();
        step(1'b1, 13'h1fff, 1'b0, 1'b0, 8'h0, 32'h100);
        chk("R1 flags", {24'b0, flags}, 32'h0);
        chk("R1 req", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_invalid_each();
        for (int i = 0; i < 9; i++) begin
            logic [7:0] exp;
            step(1'b0, '0, 1'b1, 1'b1, 8'h00, 32'h0);
            exp = 8'h01;
            if (i == 0) exp |= 8'h02;
            if (i == 1) exp |= 8'h04;
            if (i == 2 || i == 3) exp |= 8'h20;
            step(1'b1, 13'(1) << i, 1'b1, 1'b0, 8'h0, 32'h200 + 32'(i));
            chk("R2 R3 R5 invalid cause flags", {24'b0, flags}, {24'b0, exp});
            chk("R6 req", {31'b0, exc_req}, 32'h1);
            chk("R6 pc", exc_pc, 32'h200 + 32'(i));
        end
    endtask

    task automatic t_other_each();
        logic [7:0] expv [4] = '{8'h08, 8'h10, 8'h40, 8'h80};
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '0, 1'b1, 1'b1, 8'h00, 32'h0);
            step(1'b1, 13'(1) << (9 + i), 1'b1, 1'b0, 8'h0, 32'h300);
            chk("R4 R5 single flag", {24'b0, flags}, {24'b0, expv[i]});
        end
    endtask

    task automatic t_sticky_pulse();
        step(1'b0, '0, 1'b1, 1'b1, 8'h00, 32'h0);
        step(1'b1, 13'h0004, 1'b1, 1'b0, 8'h0, 32'h400);
        chk("R5 inf", {24'b0, flags}, 32'h21);
        step(1'b0, '0, 1'b1, 1'b0, 8'h0, 32'h0);
        chk("R10 pulse ends", {31'b0, exc_req}, 32'h0);
        chk("R7 held", {24'b0, flags}, 32'h21);
        step(1'b1, 13'h0, 1'b1, 1'b0, 8'h0, 32'h404);
        chk("R7 no clear", {24'b0, flags}, 32'h21);
        chk("R6 req on old flags", {31'b0, exc_req}, 32'h1);
        chk("R6 pc", exc_pc, 32'h404);
        step(1'b1, 13'h1000, 1'b1, 1'b0, 8'h0, 32'h408);
        chk("R7 accumulate", {24'b0, flags}, 32'ha1);
    endtask

    task automatic t_sw_write();
        step(1'b0, '0, 1'b1, 1'b1, 8'h5a, 32'h0);
        chk("R8 write", {24'b0, flags}, 32'h5a);
        chk("R8 no req", {31'b0, exc_req}, 32'h0);
        step(1'b0, '0, 1'b1, 1'b1, 8'h00, 32'h0);
        chk("R8 clear", {24'b0, flags}, 32'h0);
        step(1'b1, 13'h0, 1'b1, 1'b0, 8'h0, 32'h500);
        chk("R6 no flags no req", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_collide();
        step(1'b1, 13'h0200, 1'b1, 1'b1, 8'h80, 32'h600);
        chk("R9 or merge", {24'b0, flags}, 32'h88);
        chk("R9 req", {31'b0, exc_req}, 32'h1);
        step(1'b1, 13'h0001, 1'b1, 1'b1, 8'h00, 32'h604);
        chk("R9 clear plus set", {24'b0, flags}, 32'h03);
        step(1'b1, 13'h0800, 1'b0, 1'b1, 8'h10, 32'h608);
        chk("R1 R8 write wins when gated", {24'b0, flags}, 32'h10);
        chk("R1 no req", {31'b0, exc_req}, 32'h0);
    endtask

    initial begin
        st_valid = 0; st_cause = '0; prev_pc = '0; exc_en = 0;
        sw_wr_en = 0; sw_wr_data = '0; rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_gate_off();
        t_invalid_each();
        t_other_each();
        t_sticky_pulse();
        t_sw_write();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule